// File: doc/BRIEF.md
# Tagged Reconfigurable Functional Unit Dispatch

This block sits beside a processor pipeline and controls a small array of reconfigurable rows that serves as an extra functional unit. It keeps a shadow copy of the register file, updated on every register write, so the rows always see current operand values. Each row reads three operands, each taken from a shadow register or from the output of a lower-numbered row. It then applies one of four combinational functions to them. Every row carries a tag that names the custom operation it produces.

When the pipeline issues a custom operation, the block compares the opcode against all row tags at once. On a hit it stalls the pipeline until the selected row has settled, then places that row's result on the writeback bus in the same cycle that the stall drops. On a miss it stalls and raises a configuration request carrying the opcode. The stall lasts until a configuration handshake installs a row with that tag. The pipeline is expected to hold its issue inputs steady while stall is high.

Settling is modelled with a per-row countdown. The countdown is loaded with the row's configured latency when the row is written and again whenever a register that the row reads directly is written. The row counts as ready only when its own count is zero and every row it sources from is ready.

Top module: `rfu_dispatch`

## Requirements
- R1: A write on the register write port (rf_we, rf_waddr, rf_wdata) updates the shadow register at the next clock edge, and rows compute from the updated value from the following cycle on.
- R2: The function code of a row selects its result from operands a, b, c (operand 0, 1, 2). Code 0 gives a+b+c, code 1 gives a^b^c, code 2 gives (a&b)|c and code 3 gives a-b-c, all modulo 2^DATA_W.
- R3: Each operand selector is 4 bits wide. Bit 3 = 0 selects the shadow register named by bits 2:0. Bit 3 = 1 selects the output of the row named by bits 2:0. A selector that names the row itself or a higher-numbered row reads zero and does not affect readiness. Operand k is packed at cfg_src[4k+3:4k].
- R4: A row's countdown is loaded with its latency when the row is configured, or when a register it reads directly is written. It then drops by one per cycle. The row is ready only when its count is zero, no write to one of its direct registers is on the port in that cycle, and all rows it sources from are ready.
- R5: When issue_valid is high and the opcode matches a ready row, wb_valid is 1, stall is 0 and wb_data equals that row's result in the same cycle.
- R6: When issue_valid is high and the opcode matches a row that is not ready, stall is 1 and wb_valid is 0.
- R7: When issue_valid is high and no configured row holds the opcode, stall is 1. From the next cycle cfg_req is 1 and cfg_req_op equals the opcode, and both hold until cfg_done.
- R8: With cfg_done high, the next clock edge writes cfg_tag, cfg_fn, cfg_src and cfg_lat into row cfg_row, marks it configured and clears cfg_req.
- R9: When the opcode matches several rows, the lowest-numbered row supplies the result and multi_hit is 1 in that cycle; with a single match multi_hit is 0.
- R10: After reset no row is configured, all shadow registers read zero, and cfg_req, stall and wb_valid are 0.
- R11: When issue_valid is low, stall, wb_valid and multi_hit are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rf_we | input | 1 | Register file write strobe from the pipeline |
| rf_waddr | input | 3 | Register index being written |
| rf_wdata | input | DATA_W | Register value being written |
| issue_valid | input | 1 | A custom operation is being issued and held |
| issue_op | input | 4 | Custom opcode of the issued operation |
| stall | output | 1 | Pipeline must hold the issue |
| wb_valid | output | 1 | Result is on the writeback bus this cycle |
| wb_data | output | DATA_W | Result of the selected row, zero when wb_valid is low |
| multi_hit | output | 1 | Opcode matched more than one row |
| cfg_req | output | 1 | A row with cfg_req_op must be configured |
| cfg_req_op | output | 4 | Opcode that missed |
| cfg_done | input | 1 | Configuration write strobe |
| cfg_row | input | log2(NUM_ROWS) | Row to be configured |
| cfg_tag | input | 4 | Tag for the configured row |
| cfg_fn | input | 2 | Function code for the configured row |
| cfg_src | input | 12 | Three packed 4-bit operand selectors |
| cfg_lat | input | 4 | Settle latency in cycles |

## Verification
The assertions watch the miss handshake every cycle. A miss on a held issue must raise the request next cycle with the missed opcode. The request must stay with a stable opcode until the handshake and must drop right after it. A miss must always stall, a quiet issue line must keep every output low, and a multiple match must always come with a hit. The values on the writeback bus can only be shown by the bench's scenarios. The same goes for the exact number of stall cycles a latency or a dependency chain produces, the blocking effect of a write in the issue cycle and the lowest-row pick. The bench sweeps register patterns through all four functions and both source kinds, and counts stall cycles against the configured latency.

// File: rtl/rfu_disp_pkg.sv
`timescale 1ns/1ps
package rfu_disp_pkg;
    localparam int TAG_W    = 4;
    localparam int FUNC_W   = 2;
    localparam int LAT_W    = 4;
    localparam int NSRC     = 3;
    localparam int IDX_W    = 3;
    localparam int SRC_W    = IDX_W + 1;
    localparam int NUM_REGS = 1 << IDX_W;

    typedef enum logic [FUNC_W-1:0] {
        FN_SUM   = 2'd0,
        FN_XOR   = 2'd1,
        FN_ANDOR = 2'd2,
        FN_DIFF  = 2'd3
    } row_fn_e;

    typedef struct packed {
        logic             is_row;
        logic [IDX_W-1:0] idx;
    } src_sel_t;

    typedef struct packed {
        logic                      live;
        logic [TAG_W-1:0]          tag;
        row_fn_e                   fn;
        src_sel_t [NSRC-1:0]       src;
        logic [LAT_W-1:0]          lat;
    } row_cfg_t;
endpackage

// File: rtl/shadow_rf.sv
`timescale 1ns/1ps
module shadow_rf
    import rfu_disp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we_i,
    input  logic [IDX_W-1:0]                  waddr_i,
    input  logic [DATA_W-1:0]                 wdata_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0]   regs_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.regs[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.regs;
endmodule

// File: rtl/row_slot_store.sv
`timescale 1ns/1ps
module row_slot_store
    import rfu_disp_pkg::*;
#(
    parameter int NUM_ROWS = 4,
    localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_wr_i,
    input  logic [ROW_W-1:0]                  cfg_row_i,
    input  row_cfg_t                          cfg_new_i,
    input  logic                              rf_we_i,
    input  logic [IDX_W-1:0]                  rf_waddr_i,
    output row_cfg_t [NUM_ROWS-1:0]           cfg_o,
    output logic [NUM_ROWS-1:0][LAT_W-1:0]    cnt_o,
    output logic [NUM_ROWS-1:0]               touch_o
);
    typedef struct packed {
        row_cfg_t [NUM_ROWS-1:0]            cfg;
        logic [NUM_ROWS-1:0][LAT_W-1:0]     cnt;
    } slot_state_t;

    slot_state_t st_d, st_q;
    logic [NUM_ROWS-1:0] touch;

    // A row is touched when a register it reads directly is on the write port.
    always_comb begin
        for (int i = 0; i < NUM_ROWS; i++) begin
            touch[i] = 1'b0;
            for (int k = 0; k < NSRC; k++) begin
                if (rf_we_i && st_q.cfg[i].live && !st_q.cfg[i].src[k].is_row &&
                    st_q.cfg[i].src[k].idx == rf_waddr_i) begin
                    touch[i] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_ROWS; i++) begin
            if (st_q.cnt[i] != '0) begin
                st_d.cnt[i] = st_q.cnt[i] - LAT_W'(1);
            end
            if (touch[i]) begin
                st_d.cnt[i] = st_q.cfg[i].lat;
            end
            if (cfg_wr_i && cfg_row_i == ROW_W'(i)) begin
                st_d.cfg[i]      = cfg_new_i;
                st_d.cfg[i].live = 1'b1;
                st_d.cnt[i]      = cfg_new_i.lat;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o   = st_q.cfg;
    assign cnt_o   = st_q.cnt;
    assign touch_o = touch;
endmodule

// File: rtl/row_array_eval.sv
`timescale 1ns/1ps
module row_array_eval
    import rfu_disp_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_ROWS = 4
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0]   regs_i,
    input  row_cfg_t [NUM_ROWS-1:0]           cfg_i,
    input  logic [NUM_ROWS-1:0][LAT_W-1:0]    cnt_i,
    input  logic [NUM_ROWS-1:0]               touch_i,
    output logic [NUM_ROWS-1:0][DATA_W-1:0]   val_o,
    output logic [NUM_ROWS-1:0]               rdy_o
);
    logic [NUM_ROWS-1:0][DATA_W-1:0] vals;
    logic [NUM_ROWS-1:0]             rdys;
    logic                            unused_fields;

    // Rows are evaluated in ascending order so a row sees the finished
    // outputs of every lower row it names as a source.
    always_comb begin
        logic [NSRC-1:0][DATA_W-1:0] opnd;
        logic                        deps_ok;
        vals = '0;
        rdys = '0;
        for (int i = 0; i < NUM_ROWS; i++) begin
            deps_ok = 1'b1;
            for (int k = 0; k < NSRC; k++) begin
                opnd[k] = '0;
                if (!cfg_i[i].src[k].is_row) begin
                    opnd[k] = regs_i[cfg_i[i].src[k].idx];
                end else begin
                    for (int j = 0; j < NUM_ROWS; j++) begin
                        if (j < i && cfg_i[i].src[k].idx == IDX_W'(j)) begin
                            opnd[k] = vals[j];
                            deps_ok = deps_ok & rdys[j];
                        end
                    end
                end
            end
            unique case (cfg_i[i].fn)
                FN_SUM:   vals[i] = opnd[0] + opnd[1] + opnd[2];
                FN_XOR:   vals[i] = opnd[0] ^ opnd[1] ^ opnd[2];
                FN_ANDOR: vals[i] = (opnd[0] & opnd[1]) | opnd[2];
                FN_DIFF:  vals[i] = opnd[0] - opnd[1] - opnd[2];
                default:  vals[i] = '0;
            endcase
            rdys[i] = cfg_i[i].live && (cnt_i[i] == '0) && !touch_i[i] && deps_ok;
        end
    end

    always_comb begin
        unused_fields = 1'b0;
        for (int i = 0; i < NUM_ROWS; i++) begin
            unused_fields = unused_fields ^ (^cfg_i[i].tag) ^ (^cfg_i[i].lat);
        end
    end

    assign val_o = vals;
    assign rdy_o = rdys;
endmodule

// File: rtl/tag_select.sv
`timescale 1ns/1ps
module tag_select
    import rfu_disp_pkg::*;
#(
    parameter int NUM_ROWS = 4,
    localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  row_cfg_t [NUM_ROWS-1:0]   cfg_i,
    input  logic [TAG_W-1:0]          op_i,
    output logic                      hit_o,
    output logic                      multi_o,
    output logic [ROW_W-1:0]          sel_o
);
    logic [NUM_ROWS-1:0] match;
    logic                unused_fields;

    always_comb begin
        for (int i = 0; i < NUM_ROWS; i++) begin
            match[i] = cfg_i[i].live && (cfg_i[i].tag == op_i);
        end
    end

    // Scan from the top so the lowest matching row wins.
    always_comb begin
        sel_o = '0;
        for (int i = NUM_ROWS - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel_o = ROW_W'(i);
            end
        end
        hit_o   = |match;
        multi_o = ($countones(match) > 1);
    end

    always_comb begin
        unused_fields = 1'b0;
        for (int i = 0; i < NUM_ROWS; i++) begin
            unused_fields = unused_fields ^ (^cfg_i[i].fn) ^ (^cfg_i[i].src) ^ (^cfg_i[i].lat);
        end
    end
endmodule

// File: rtl/rfu_dispatch.sv
`timescale 1ns/1ps
module rfu_dispatch
    import rfu_disp_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_ROWS = 4,
    localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rf_we,
    input  logic [IDX_W-1:0]          rf_waddr,
    input  logic [DATA_W-1:0]         rf_wdata,
    input  logic                      issue_valid,
    input  logic [TAG_W-1:0]          issue_op,
    output logic                      stall,
    output logic                      wb_valid,
    output logic [DATA_W-1:0]         wb_data,
    output logic                      multi_hit,
    output logic                      cfg_req,
    output logic [TAG_W-1:0]          cfg_req_op,
    input  logic                      cfg_done,
    input  logic [ROW_W-1:0]          cfg_row,
    input  logic [TAG_W-1:0]          cfg_tag,
    input  logic [FUNC_W-1:0]         cfg_fn,
    input  logic [NSRC*SRC_W-1:0]     cfg_src,
    input  logic [LAT_W-1:0]          cfg_lat
);
    typedef struct packed {
        logic             pend;
        logic [TAG_W-1:0] op;
    } req_state_t;

    logic [NUM_REGS-1:0][DATA_W-1:0]  shadow;
    row_cfg_t [NUM_ROWS-1:0]          row_cfg;
    logic [NUM_ROWS-1:0][LAT_W-1:0]   row_cnt;
    logic [NUM_ROWS-1:0]              row_touch;
    logic [NUM_ROWS-1:0][DATA_W-1:0]  row_val;
    logic [NUM_ROWS-1:0]              row_rdy;
    logic                             op_hit;
    logic                             op_multi;
    logic [ROW_W-1:0]                 op_sel;
    logic                             op_go;
    row_cfg_t                         cfg_new;
    req_state_t                       st_d, st_q;

    always_comb begin
        cfg_new      = '0;
        cfg_new.live = 1'b1;
        cfg_new.tag  = cfg_tag;
        cfg_new.fn   = row_fn_e'(cfg_fn);
        cfg_new.src  = cfg_src;
        cfg_new.lat  = cfg_lat;
    end

    shadow_rf #(.DATA_W(DATA_W)) i_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (rf_we),
        .waddr_i (rf_waddr),
        .wdata_i (rf_wdata),
        .regs_o  (shadow)
    );

    row_slot_store #(.NUM_ROWS(NUM_ROWS)) i_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_i   (cfg_done),
        .cfg_row_i  (cfg_row),
        .cfg_new_i  (cfg_new),
        .rf_we_i    (rf_we),
        .rf_waddr_i (rf_waddr),
        .cfg_o      (row_cfg),
        .cnt_o      (row_cnt),
        .touch_o    (row_touch)
    );

    row_array_eval #(.DATA_W(DATA_W), .NUM_ROWS(NUM_ROWS)) i_eval (
        .regs_i  (shadow),
        .cfg_i   (row_cfg),
        .cnt_i   (row_cnt),
        .touch_i (row_touch),
        .val_o   (row_val),
        .rdy_o   (row_rdy)
    );

    tag_select #(.NUM_ROWS(NUM_ROWS)) i_match (
        .cfg_i   (row_cfg),
        .op_i    (issue_op),
        .hit_o   (op_hit),
        .multi_o (op_multi),
        .sel_o   (op_sel)
    );

    // Miss request: raised one cycle after a miss, held until a row is written.
    always_comb begin
        st_d = st_q;
        if (cfg_done) begin
            st_d.pend = 1'b0;
        end else if (issue_valid && !op_hit && !st_q.pend) begin
            st_d.pend = 1'b1;
            st_d.op   = issue_op;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign op_go      = op_hit && row_rdy[op_sel];
    assign stall      = issue_valid && !op_go;
    assign wb_valid   = issue_valid && op_go;
    assign wb_data    = wb_valid ? row_val[op_sel] : '0;
    assign multi_hit  = issue_valid && op_multi;
    assign cfg_req    = st_q.pend;
    assign cfg_req_op = st_q.op;
endmodule

// File: rtl/rfu_dispatch_chk.sv
`timescale 1ns/1ps
module rfu_dispatch_chk
    import rfu_disp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             issue_valid,
    input logic [TAG_W-1:0] issue_op,
    input logic             stall,
    input logic             wb_valid,
    input logic             multi_hit,
    input logic             cfg_req,
    input logic [TAG_W-1:0] cfg_req_op,
    input logic             cfg_done,
    input logic             op_hit
);
    assert_miss_raises_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !op_hit && !cfg_req && !cfg_done |=> cfg_req && (cfg_req_op == $past(issue_op)));

    assert_request_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req && !cfg_done |=> cfg_req && $stable(cfg_req_op));

    assert_miss_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !op_hit |-> stall && !wb_valid);

    assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> !cfg_req);

    assert_multi_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> op_hit && issue_valid);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> !stall && !wb_valid && !multi_hit);

    assert_wb_excludes_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> op_hit && !stall);
endmodule

bind rfu_dispatch rfu_dispatch_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_op    (issue_op),
    .stall       (stall),
    .wb_valid    (wb_valid),
    .multi_hit   (multi_hit),
    .cfg_req     (cfg_req),
    .cfg_req_op  (cfg_req_op),
    .cfg_done    (cfg_done),
    .op_hit      (op_hit)
);

// File: tb/test_rfu_dispatch.sv
`timescale 1ns/1ps
module test_rfu_dispatch;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rf_we = 1'b0;
    logic [2:0]      rf_waddr = '0;
    logic [DW-1:0]   rf_wdata = '0;
    logic            issue_valid = 1'b0;
    logic [3:0]      issue_op = '0;
    logic            stall, wb_valid, multi_hit, cfg_req;
    logic [DW-1:0]   wb_data;
    logic [3:0]      cfg_req_op;
    logic            cfg_done = 1'b0;
    logic [1:0]      cfg_row = '0;
    logic [3:0]      cfg_tag = '0;
    logic [1:0]      cfg_fn = '0;
    logic [11:0]     cfg_src = '0;
    logic [3:0]      cfg_lat = '0;

    int total = 0;
    int bad = 0;

    logic [DW-1:0] m_reg [8];
    int            m_fn  [4];
    int            m_src [4][3];

    always #2 clk = ~clk;

    rfu_dispatch #(.DATA_W(DW), .NUM_ROWS(4)) i_rfu_dispatch (
        .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .issue_valid(issue_valid), .issue_op(issue_op), .stall(stall), .wb_valid(wb_valid),
        .wb_data(wb_data), .multi_hit(multi_hit), .cfg_req(cfg_req), .cfg_req_op(cfg_req_op),
        .cfg_done(cfg_done), .cfg_row(cfg_row), .cfg_tag(cfg_tag), .cfg_fn(cfg_fn),
        .cfg_src(cfg_src), .cfg_lat(cfg_lat)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected row result from the requirement text (R2, R3).
    function automatic logic [DW-1:0] model(input int row);
        logic [DW-1:0] v [4];
        logic [DW-1:0] o [3];
        for (int i = 0; i <= row; i++) begin
            for (int k = 0; k < 3; k++) begin
                if (m_src[i][k] < 8) o[k] = m_reg[m_src[i][k]];
                else if (m_src[i][k] - 8 < i) o[k] = v[m_src[i][k] - 8];
                else o[k] = '0;
            end
            case (m_fn[i])
                0: v[i] = o[0] + o[1] + o[2];
                1: v[i] = o[0] ^ o[1] ^ o[2];
                2: v[i] = (o[0] & o[1]) | o[2];
                default: v[i] = o[0] - o[1] - o[2];
            endcase
        end
        return v[row];
    endfunction

    // Called right after a negedge; returns right after the next negedge.
    task automatic load_row(input int row, input int tag, input int fn,
                            input int s0, input int s1, input int s2, input int lat);
        m_fn[row] = fn;
        m_src[row][0] = s0; m_src[row][1] = s1; m_src[row][2] = s2;
        cfg_done = 1'b1;
        cfg_row  = 2'(row);
        cfg_tag  = 4'(tag);
        cfg_fn   = 2'(fn);
        cfg_src  = {4'(s2), 4'(s1), 4'(s0)};
        cfg_lat  = 4'(lat);
        @(negedge clk);
        cfg_done = 1'b0;
    endtask

    task automatic write_reg(input int r, input logic [DW-1:0] v);
        rf_we = 1'b1; rf_waddr = 3'(r); rf_wdata = v;
        m_reg[r] = v;
        @(negedge clk);
        rf_we = 1'b0;
    endtask

    task automatic issue_expect(input int op, input int row, input string req);
        issue_valid = 1'b1; issue_op = 4'(op);
        #1;
        chk({req, " wb_valid"}, 32'(wb_valid), 32'd1);
        chk({req, " wb_data"}, 32'(wb_data), 32'(model(row)));
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    // Issue op together with a write; count later stall cycles before writeback.
    task automatic write_issue_count(input int r, input logic [DW-1:0] v, input int op,
                                     input int row, input int exp_cnt, input string req);
        int n;
        rf_we = 1'b1; rf_waddr = 3'(r); rf_wdata = v; m_reg[r] = v;
        issue_valid = 1'b1; issue_op = 4'(op);
        #1;
        chk({req, " stall during write"}, 32'(stall), 32'd1);
        @(negedge clk);
        rf_we = 1'b0;
        n = 0;
        for (int t = 0; t < 12; t++) begin
            #1;
            if (wb_valid) break;
            if (stall) n++;
            @(negedge clk);
        end
        chk({req, " stall cycles"}, 32'(n), 32'(exp_cnt));
        chk({req, " data after settle"}, 32'(wb_data), 32'(model(row)));
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < 8; r++) m_reg[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10 cfg_req after reset", 32'(cfg_req), 32'd0);
        chk("R10 stall after reset", 32'(stall), 32'd0);
        chk("R10 wb_valid after reset", 32'(wb_valid), 32'd0);
        @(negedge clk);

        // R10/R7: nothing configured, so op 1 misses
        issue_valid = 1'b1; issue_op = 4'd1;
        #1;
        chk("R10 R7 miss stall", 32'(stall), 32'd1);
        chk("R7 no request yet", 32'(cfg_req), 32'd0);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk); #1;
            chk("R7 request raised", 32'(cfg_req), 32'd1);
            chk("R7 request opcode", 32'(cfg_req_op), 32'd1);
            chk("R7 still stalled", 32'(stall), 32'd1);
        end
        @(negedge clk);
        // R8: install row0 = sum of r0,r1,r2 with issue still held
        load_row(0, 1, 0, 0, 1, 2, 0);
        #1;
        chk("R8 request cleared", 32'(cfg_req), 32'd0);
        chk("R8 R5 hit after install", 32'(wb_valid), 32'd1);
        chk("R10 shadow zero result", 32'(wb_data), 32'd0);
        @(negedge clk);
        issue_valid = 1'b0;

        // Remaining rows: row sources use code 8+row (R3)
        load_row(1, 2, 1, 3, 8, 4, 0);    // r3 ^ row0 ^ r4
        load_row(2, 3, 2, 5, 6, 9, 0);    // (r5 & r6) | row1
        load_row(3, 4, 3, 7, 10, 11, 0);  // r7 - row2 - self(=0)
        #1;
        chk("R8 config alone raises no request", 32'(cfg_req), 32'd0);
        @(negedge clk);

        // R1 R2 R3 R5: sweep register patterns through all rows
        for (int p = 0; p < 10; p++) begin
            for (int r = 0; r < 8; r++) begin
                write_reg(r, 16'((p + 1) * 16'h2b37) ^ 16'(r * 16'h01f3 + p * r * 7));
            end
            for (int op = 1; op <= 4; op++) begin
                issue_expect(op, op - 1, "R1 R2 R3 R5 sweep");
            end
        end

        // R4: row0 latency 3, write in the issue cycle blocks
        load_row(0, 1, 0, 0, 1, 2, 3);
        repeat (5) @(negedge clk);
        write_issue_count(0, 16'h1234, 1, 0, 3, "R4 R6 latency direct");
        // R4: row1 waits on row0 through its row source
        write_issue_count(1, 16'h0f0f, 2, 1, 3, "R4 R6 dependent row");
        // R4: zero-latency row still blocked by a same-cycle write
        write_issue_count(3, 16'hbeef, 2, 1, 0, "R4 write in issue cycle");

        // R7 R8: a second miss, installed into row2
        issue_valid = 1'b1; issue_op = 4'd9;
        #1;
        chk("R7 second miss stall", 32'(stall), 32'd1);
        @(negedge clk); #1;
        chk("R7 second request", 32'(cfg_req), 32'd1);
        chk("R7 second opcode", 32'(cfg_req_op), 32'd9);
        @(negedge clk);
        load_row(2, 9, 1, 0, 1, 2, 0);
        #1;
        chk("R8 second install wb", 32'(wb_valid), 32'd1);
        chk("R8 second install data", 32'(wb_data), 32'(model(2)));
        chk("R9 single match flag", 32'(multi_hit), 32'd0);
        @(negedge clk);
        issue_valid = 1'b0;

        // R9: row3 also tagged 2; lowest row (1) must answer
        load_row(3, 2, 0, 0, 0, 0, 0);
        issue_valid = 1'b1; issue_op = 4'd2;
        #1;
        chk("R9 multi flag", 32'(multi_hit), 32'd1);
        chk("R9 lowest row data", 32'(wb_data), 32'(model(1)));
        @(negedge clk);

        // R11: issue dropped with a matching opcode on the bus
        issue_valid = 1'b0;
        #1;
        chk("R11 stall idle", 32'(stall), 32'd0);
        chk("R11 wb idle", 32'(wb_valid), 32'd0);
        chk("R11 multi idle", 32'(multi_hit), 32'd0);
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule